// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block brings a switchable logic domain up and takes it back down in hardware. Software starts a sequence by writing a command word on a simple write port. The block then steps through the power-switch, inrush-limit, isolation and memory-repair controls on its own. It watches two status inputs from the domain: power-good and repair-done.

During power-up the block closes the switches at the gentlest inrush code. If power-good does not appear in time, it raises the code one step. Once power-good arrives, it lifts electrical isolation and asks for a memory repair. When the repair completes, it lifts functional isolation. A timeout at any point leads to an orderly rollback, and the error output pulses. Power-down applies the isolations in reverse order and then opens the switches.

While a sequence runs, `busy` is high. At the end of a sequence, `done` or `err` pulses for one cycle. A 32-bit status word mirrors the control and status bits.

The machine has these states:
- `S_IDLE`: waiting for a command.
- `S_RAMP`: switches closed, waiting for power-good at the current inrush code.
- `S_EISO`: electrical isolation has just been released.
- `S_REPAIR`: repair requested, waiting for repair-done.
- `S_UNDO`: rollback that clears the switch and inrush controls.
- `S_DN_EISO`: re-applying electrical isolation during power-down.
- `S_DN_SW`: opening the switches during power-down.

The transitions are:
- `S_IDLE`→`S_RAMP` on an up command while the switches are open.
- `S_IDLE`→`S_DN_EISO` on a down command.
- `S_RAMP`→`S_EISO` on power-good.
- `S_RAMP`→`S_RAMP` on a level timeout below the top code.
- `S_RAMP`→`S_UNDO` on a timeout at the top code.
- `S_EISO`→`S_REPAIR` unconditionally.
- `S_REPAIR`→`S_IDLE` on repair-done.
- `S_REPAIR`→`S_UNDO` on repair timeout.
- `S_UNDO`→`S_IDLE`, `S_DN_EISO`→`S_DN_SW` and `S_DN_SW`→`S_IDLE`, each unconditionally.

Top module: `pds_seq`

## Requirements
- R1: A write is accepted only when `wr_data[31:24]` equals 0x5A. Any other write changes no output, and `busy` stays low.
- R2: An accepted write decodes `wr_data[1:0]`: 01 requests power-up, 10 requests power-down, and 00 or 11 does nothing.
- R3: Power-up sets switch enable and inrush code 0 on the accepting edge. Each code lasts PG_CYC cycles (150 at 50 MHz, from 3 µs) without power-good, after which the code rises by one, up to code 3.
- R4: Power-good seen at code K stops the ramp, and the inrush field stays at K.
- R5: If power-good never comes at codes 0 to 3, switch enable and the inrush field clear on the same edge and `err` pulses. `busy` is high for 4·PG_CYC+1 cycles.
- R6: Electrical isolation is released on the edge after power-good is seen. The repair request rises one cycle later. The edge that sees repair-done releases functional isolation, drops the repair request, sets domain enable and pulses `done`. Repair-done arriving R cycles after the request gives `busy` K·PG_CYC+2+R cycles, valid for R up to REP_CYC (50 cycles, from 1 µs).
- R7: With no repair-done within REP_CYC cycles, electrical isolation is re-applied. One cycle later switch enable and inrush clear and `err` pulses, for K·PG_CYC+REP_CYC+3 busy cycles.
- R8: A power-up request while switch enable is set is ignored: no `busy`, no `done`, and the outputs are unchanged.
- R9: Power-down clears functional isolation on the accepting edge and electrical isolation one edge later. One edge after that it clears switch enable, inrush and domain enable and pulses `done`, so `busy` is high for 2 cycles.
- R10: A valid command accepted while `busy` is held, and it starts once the running sequence ends. A later command replaces an earlier held one.
- R11: The status word has switch enable at bit 0, power-good at bit 1, electrical isolation release at bit 2, repair request at bit 3, repair-done at bit 4, functional isolation release at bit 5, domain enable at bit 12 and the inrush code at bits 14:13. All other bits are 0.
- R12: Functional isolation release implies electrical isolation release, which implies switch enable. The repair request implies electrical isolation release.
- R13: `done` and `err` are one-cycle pulses, never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Command write strobe |
| wr_data | input | 32 | Command word: key in [31:24], opcode in [1:0] |
| pwr_good | input | 1 | Domain supply has settled |
| repair_done | input | 1 | Memory repair finished |
| sw_en | output | 1 | Power-switch enable |
| inrush_lim | output | 2 | Inrush-current limit code (0 lowest) |
| eiso_rel | output | 1 | Electrical isolation released |
| mem_rep_req | output | 1 | Memory repair request |
| fiso_rel | output | 1 | Functional isolation released |
| dom_en | output | 1 | Domain fully up |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on rollback |
| ctrl_word | output | 32 | Status word, layout per R11 |

## Verification
The assertions assume that power-good only stays high while the switches are closed. They also assume that repair-done only answers a pending repair request. The bench's domain model keeps within both assumptions: it raises power-good one cycle after the inrush code reaches a chosen threshold with the switch enabled, and drops it once the switch opens. Repair-done follows the request by a chosen latency and falls as soon as the request drops.

The sweep covers every threshold from 0 to 3, plus one that is never reached. It also places repair latencies at 1, at REP_CYC and at REP_CYC+1, so both timeout edges are met exactly.

// File: rtl/pds_pkg.sv
package pds_pkg;
    localparam logic [7:0] WR_KEY = 8'h5A;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_UP   = 2'b01,
        OP_DOWN = 2'b10,
        OP_RSVD = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RAMP,
        S_EISO,
        S_REPAIR,
        S_UNDO,
        S_DN_EISO,
        S_DN_SW
    } state_e;

    typedef struct packed {
        logic [1:0] inrush;
        logic       dom;
        logic       fiso;
        logic       rep;
        logic       eiso;
        logic       sw;
    } ctl_t;
endpackage

// File: rtl/pds_timer.sv
module pds_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (cnt != {W{1'b1}})
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pds_req.sv
module pds_req
    import pds_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_valid,
    input  logic [7:0] wr_key,
    input  logic [1:0] wr_opc,
    input  logic       busy,
    output logic       start_up,
    output logic       start_dn
);
    logic key_ok;
    logic op_ok;
    op_e  wr_op;
    op_e  pend_q;
    op_e  issue;

    assign key_ok = wr_valid && (wr_key == WR_KEY);
    assign wr_op  = op_e'(wr_opc);
    assign op_ok  = key_ok && (wr_op == OP_UP || wr_op == OP_DOWN);

    always_comb begin
        issue = op_ok ? wr_op : pend_q;
    end

    assign start_up = !busy && (issue == OP_UP);
    assign start_dn = !busy && (issue == OP_DOWN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= OP_NONE;
        else if (!busy)
            pend_q <= OP_NONE;
        else if (op_ok)
            pend_q <= wr_op;
    end

    // R1
    key_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_ok && pend_q == OP_NONE) |-> (!start_up && !start_dn));

    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_ok) |=> (pend_q == $past(pend_q) || !$past(busy)));
endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
    import pds_pkg::*;
#(
    parameter int PG_CYC  = 150,
    parameter int REP_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_up,
    input  logic start_dn,
    input  logic pwr_good,
    input  logic repair_done,
    output ctl_t ctl,
    output logic busy,
    output logic done,
    output logic err
);
    localparam int LONGEST = (PG_CYC > REP_CYC) ? PG_CYC : REP_CYC;
    localparam int TW = $clog2(LONGEST + 1);
    localparam logic [1:0] TOP_CODE = 2'b11;

    state_e        state_q;
    state_e        state_d;
    logic [TW-1:0] cnt;
    logic          tclr;
    logic          pg_to;
    logic          rep_to;
    logic          ramp_step;

    assign pg_to     = (cnt == TW'(PG_CYC - 1));
    assign rep_to    = (cnt == TW'(REP_CYC - 1));
    assign ramp_step = (state_q == S_RAMP) && !pwr_good && pg_to;
    assign tclr      = !(state_q == S_RAMP || state_q == S_REPAIR) || ramp_step;
    assign busy      = (state_q != S_IDLE);

    pds_timer #(.W(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tclr),
        .cnt   (cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_up && !ctl.sw) state_d = S_RAMP;
                else if (start_dn)       state_d = S_DN_EISO;
            end
            S_RAMP: begin
                if (pwr_good)                          state_d = S_EISO;
                else if (pg_to && ctl.inrush == TOP_CODE) state_d = S_UNDO;
            end
            S_EISO:    state_d = S_REPAIR;
            S_REPAIR: begin
                if (repair_done) state_d = S_IDLE;
                else if (rep_to) state_d = S_UNDO;
            end
            S_UNDO:    state_d = S_IDLE;
            S_DN_EISO: state_d = S_DN_SW;
            S_DN_SW:   state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl  <= '0;
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start_up && !ctl.sw) begin
                        ctl.sw     <= 1'b1;
                        ctl.inrush <= 2'b00;
                    end else if (start_dn) begin
                        ctl.fiso <= 1'b0;
                    end
                end
                S_RAMP: begin
                    if (pwr_good)
                        ctl.eiso <= 1'b1;
                    else if (pg_to && ctl.inrush != TOP_CODE)
                        ctl.inrush <= ctl.inrush + 2'b01;
                end
                S_EISO: ctl.rep <= 1'b1;
                S_REPAIR: begin
                    if (repair_done) begin
                        ctl.rep  <= 1'b0;
                        ctl.fiso <= 1'b1;
                        ctl.dom  <= 1'b1;
                        done     <= 1'b1;
                    end else if (rep_to) begin
                        ctl.rep  <= 1'b0;
                        ctl.eiso <= 1'b0;
                    end
                end
                S_UNDO: begin
                    ctl.sw     <= 1'b0;
                    ctl.inrush <= 2'b00;
                    err        <= 1'b1;
                end
                S_DN_EISO: ctl.eiso <= 1'b0;
                S_DN_SW: begin
                    ctl.sw     <= 1'b0;
                    ctl.inrush <= 2'b00;
                    ctl.dom    <= 1'b0;
                    done       <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R12
    fiso_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.fiso |-> ctl.eiso);
    // R12
    eiso_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.eiso |-> ctl.sw);
    // R12
    rep_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.rep |-> ctl.eiso);
    // R3
    inrush_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.sw && $past(ctl.sw)) |-> (ctl.inrush >= $past(ctl.inrush)));
    // R5
    rollback_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl.sw) |-> (ctl.inrush == 2'b00 && !ctl.eiso));
    // R8
    ignore_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start_up && ctl.sw) |=> (state_q == S_IDLE));
    // R13
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/pds_seq.sv
module pds_seq
    import pds_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int PG_WAIT_NS  = 3000,
    parameter int REP_WAIT_NS = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_valid,
    input  logic [31:0] wr_data,
    input  logic        pwr_good,
    input  logic        repair_done,
    output logic        sw_en,
    output logic [1:0]  inrush_lim,
    output logic        eiso_rel,
    output logic        mem_rep_req,
    output logic        fiso_rel,
    output logic        dom_en,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [31:0] ctrl_word
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int PG_RAW     = CYC_PER_US * PG_WAIT_NS / 1000;
    localparam int REP_RAW    = CYC_PER_US * REP_WAIT_NS / 1000;
    localparam int PG_CYC     = (PG_RAW < 1) ? 1 : PG_RAW;
    localparam int REP_CYC    = (REP_RAW < 1) ? 1 : REP_RAW;

    logic start_up;
    logic start_dn;
    ctl_t ctl;
    logic unused_wr;

    assign unused_wr = ^wr_data[23:2];

    pds_req u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_key   (wr_data[31:24]),
        .wr_opc   (wr_data[1:0]),
        .busy     (busy),
        .start_up (start_up),
        .start_dn (start_dn)
    );

    pds_fsm #(.PG_CYC(PG_CYC), .REP_CYC(REP_CYC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_up    (start_up),
        .start_dn    (start_dn),
        .pwr_good    (pwr_good),
        .repair_done (repair_done),
        .ctl         (ctl),
        .busy        (busy),
        .done        (done),
        .err         (err)
    );

    assign sw_en       = ctl.sw;
    assign inrush_lim  = ctl.inrush;
    assign eiso_rel    = ctl.eiso;
    assign mem_rep_req = ctl.rep;
    assign fiso_rel    = ctl.fiso;
    assign dom_en      = ctl.dom;

    assign ctrl_word = {17'd0, ctl.inrush, ctl.dom, 6'd0, ctl.fiso, repair_done,
                        ctl.rep, ctl.eiso, pwr_good, ctl.sw};

    // R11
    word_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word[31:15] == 17'd0 && ctrl_word[11:6] == 6'd0));
endmodule

// File: tb/pds_seq_tb.sv
module pds_seq_tb;
    localparam int PG  = 50 * 3000 / 1000;
    localparam int REP = 50 * 1000 / 1000;
    localparam logic [31:0] CMD_UP = 32'h5A00_0001;
    localparam logic [31:0] CMD_DN = 32'h5A00_0002;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        pwr_good = 1'b0;
    logic        repair_done = 1'b0;
    logic        sw_en, eiso_rel, mem_rep_req, fiso_rel, dom_en, busy, done, err;
    logic [1:0]  inrush_lim;
    logic [31:0] ctrl_word;

    int n_chk = 0;
    int n_fail = 0;
    int k_thr = 4;
    int r_lat = 1;
    int rcnt = 0;
    int nb, ix_eiso_r, ix_rep_r, ix_fiso_r, ix_eiso_f, ix_fiso_f, ix_sw_f, n_done, n_err;
    int ix_code [4];

    always #10 clk = ~clk;

    pds_seq u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .pwr_good(pwr_good), .repair_done(repair_done), .sw_en(sw_en),
        .inrush_lim(inrush_lim), .eiso_rel(eiso_rel), .mem_rep_req(mem_rep_req),
        .fiso_rel(fiso_rel), .dom_en(dom_en), .busy(busy), .done(done), .err(err),
        .ctrl_word(ctrl_word)
    );

    // domain model: power-good and repair-done
    always @(negedge clk) begin
        pwr_good <= sw_en && (int'(inrush_lim) >= k_thr);
        if (mem_rep_req) rcnt <= rcnt + 1;
        else             rcnt <= 0;
        repair_done <= mem_rep_req && (rcnt + 1 >= r_lat);
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] data);
        logic p_eiso, p_rep, p_fiso, p_sw;
        @(negedge clk);
        p_eiso = eiso_rel; p_rep = mem_rep_req; p_fiso = fiso_rel; p_sw = sw_en;
        wr_valid = 1'b1; wr_data = data;
        @(negedge clk);
        wr_valid = 1'b0; wr_data = '0;
        #1;
        ix_eiso_r = -1; ix_rep_r = -1; ix_fiso_r = -1;
        ix_eiso_f = -1; ix_fiso_f = -1; ix_sw_f = -1;
        n_done = 0; n_err = 0; nb = -1;
        for (int c = 0; c < 4; c++) ix_code[c] = -1;
        for (int i = 0; i < 5000; i++) begin
            if (sw_en && ix_code[inrush_lim] < 0) ix_code[inrush_lim] = i;
            if (eiso_rel && !p_eiso && ix_eiso_r < 0) ix_eiso_r = i;
            if (!eiso_rel && p_eiso && ix_eiso_f < 0) ix_eiso_f = i;
            if (mem_rep_req && !p_rep && ix_rep_r < 0) ix_rep_r = i;
            if (fiso_rel && !p_fiso && ix_fiso_r < 0) ix_fiso_r = i;
            if (!fiso_rel && p_fiso && ix_fiso_f < 0) ix_fiso_f = i;
            if (!sw_en && p_sw && ix_sw_f < 0) ix_sw_f = i;
            p_eiso = eiso_rel; p_rep = mem_rep_req; p_fiso = fiso_rel; p_sw = sw_en;
            if (done) n_done++;
            if (err) n_err++;
            if (!busy) begin
                nb = i;
                break;
            end
            @(negedge clk);
            #1;
        end
    endtask

    task automatic check_up_ok(input int k, input int r);
        chk(nb == k * PG + 2 + r, "R6 busy length", nb, k * PG + 2 + r);
        chk(inrush_lim == 2'(k), "R4 final inrush", inrush_lim, k);
        for (int c = 0; c <= k; c++)
            chk(ix_code[c] == c * PG, "R3 code step time", ix_code[c], c * PG);
        chk(ix_eiso_r == k * PG + 1, "R6 eiso release", ix_eiso_r, k * PG + 1);
        chk(ix_rep_r == ix_eiso_r + 1, "R6 repair after eiso", ix_rep_r, ix_eiso_r + 1);
        chk(ix_fiso_r == ix_rep_r + r, "R6 fiso after repair", ix_fiso_r, ix_rep_r + r);
        chk(n_done == 1 && n_err == 0, "R13 done pulse", {n_done, n_err}, 1 << 32);
        chk(dom_en == 1'b1 && mem_rep_req == 1'b0, "R6 domain up", {dom_en, mem_rep_req}, 2);
        chk(ctrl_word == (32'h27 | 32'h1000 | (32'(k) << 13)), "R11 status word",
            ctrl_word, 32'h27 | 32'h1000 | (32'(k) << 13));
    endtask

    task automatic check_down;
        run_op(CMD_DN);
        chk(nb == 2, "R9 down busy", nb, 2);
        chk(ix_fiso_f == 0 && ix_eiso_f == 1 && ix_sw_f == 2, "R9 down order",
            {ix_fiso_f[7:0], ix_eiso_f[7:0], ix_sw_f[7:0]}, 24'h000102);
        chk(n_done == 1, "R9 done pulse", n_done, 1);
        chk(ctrl_word == 32'h0, "R11 word after down", ctrl_word, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(ctrl_word == 32'h0 && !busy && !done && !err, "R11 reset state", ctrl_word, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: wrong key
        run_op(32'h5B00_0001);
        chk(nb == 0 && !sw_en, "R1 bad key ignored", {nb[7:0], sw_en}, 0);
        // R2: reserved and empty opcodes
        run_op(32'h5A00_0003);
        chk(nb == 0 && !sw_en, "R2 opcode 11 no-op", {nb[7:0], sw_en}, 0);
        run_op(32'h5A00_0000);
        chk(nb == 0 && !sw_en, "R2 opcode 00 no-op", {nb[7:0], sw_en}, 0);

        // threshold sweep, R3 R4 R5 R6
        for (int k = 0; k <= 4; k++) begin
            k_thr = k;
            r_lat = 2;
            run_op(CMD_UP);
            if (k < 4) begin
                check_up_ok(k, 2);
                if (k == 2) begin
                    // R8: up while switched on
                    run_op(CMD_UP);
                    chk(nb == 0 && n_done == 0 && dom_en && inrush_lim == 2'd2,
                        "R8 up ignored", {nb[7:0], n_done[7:0]}, 0);
                    // R1: bad key down while on
                    run_op(32'h0000_0002);
                    chk(nb == 0 && dom_en && sw_en, "R1 bad key down", nb, 0);
                end
                check_down();
            end else begin
                chk(nb == 4 * PG + 1, "R5 ramp fail length", nb, 4 * PG + 1);
                for (int c = 0; c < 4; c++)
                    chk(ix_code[c] == c * PG, "R3 code step time", ix_code[c], c * PG);
                chk(ix_sw_f == nb && !sw_en && inrush_lim == 2'd0, "R5 switch cleared",
                    ix_sw_f, nb);
                chk(n_err == 1 && n_done == 0, "R5 err pulse", {n_err, n_done}, 1 << 32);
            end
        end

        // R6 boundary: repair at the last allowed cycle
        k_thr = 0;
        r_lat = REP;
        run_op(CMD_UP);
        check_up_ok(0, REP);
        check_down();

        // R7: repair one cycle too late
        k_thr = 1;
        r_lat = REP + 1;
        run_op(CMD_UP);
        chk(nb == PG + REP + 3, "R7 repair timeout length", nb, PG + REP + 3);
        chk(ix_eiso_f == PG + REP + 2, "R7 eiso reapplied", ix_eiso_f, PG + REP + 2);
        chk(ix_sw_f == PG + REP + 3, "R7 switch cleared after", ix_sw_f, PG + REP + 3);
        chk(n_err == 1 && n_done == 0 && !sw_en && inrush_lim == 2'd0, "R7 err pulse",
            {n_err, n_done}, 1 << 32);

        // R10: down held while up runs
        k_thr = 3;
        r_lat = 1;
        begin
            int dn = 0;
            bit seen_dom = 0;
            @(negedge clk);
            wr_valid = 1'b1; wr_data = CMD_UP;
            @(negedge clk);
            wr_valid = 1'b0;
            repeat (5) @(negedge clk);
            wr_valid = 1'b1; wr_data = CMD_DN;
            @(negedge clk);
            wr_valid = 1'b0; wr_data = '0;
            for (int i = 0; i < 3 * PG + 40; i++) begin
                #1;
                if (done) dn++;
                if (dom_en) seen_dom = 1;
                @(negedge clk);
            end
            chk(dn == 2, "R10 both sequences done", dn, 2);
            chk(seen_dom, "R10 up completed first", seen_dom, 1);
            chk(!sw_en && !busy && !dom_en, "R10 held down ran", {sw_en, busy, dom_en}, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule